// File: doc/BRIEF.md
# CAN Controller Status and Wakeup Register

This block is the 32-bit status word of a CAN controller. It shows the level of the receive line and the receive value taken at the most recent sample point. It shows whether the controller is transmitting or receiving. It also carries the sleep and init acknowledge levels from the mode logic, plus three sticky event flags:

- sleep entered
- wakeup on a start-of-frame seen during sleep
- error pulse

Software reads the word through a plain read/write port. Software clears an event flag by writing 1 to its bit.

The receive input first passes through a multi-stage synchronizer. A start-of-frame is a falling edge, recessive to dominant, on the synchronized line. The three flags are combined through separate enable inputs into one registered status-change interrupt. The bit-timing logic supplies a one-cycle sample strobe. The mode logic supplies the acknowledge levels and the transmit and receive mode levels.

Top module: `can_stat_reg`

## Requirements
- R1: During and after synchronous reset, `rd_data` reads 0x0000_0C02. The receive line bit and the sample bit are 1, init acknowledge is 1, and all other bits are 0.
- R2: Bits 31:12 and 7:5 of `rd_data` always read 0. Writing ones to them changes nothing.
- R3: Bit 11 follows `rx_pin` through a two-flop synchronizer. A change becomes visible after exactly two rising clock edges.
- R4: Bit 10 takes the synchronized receive value on each edge where `sample_tick` is 1. It holds that value while `sample_tick` is 0.
- R5: Bit 9 = `mode_rx`, bit 8 = `mode_tx`, bit 1 = `init_ack` and bit 0 = `sleep_ack`. Each is registered and appears one edge after the input changes.
- R6: Bit 4 (sleep event) sets one edge after bit 0 rises, and only if `ie_sleep` is 1. With `ie_sleep` at 0 it stays 0.
- R7: Bit 4 clears on a write with bit 4 = 1. It also clears by itself one edge after bit 0 reads 0.
- R8: Bit 3 (wakeup) sets one edge after the synchronized receive line falls while bit 0 is 1. A fall while bit 0 is 0 leaves it at 0. Only a write with bit 3 = 1 clears it.
- R9: Bit 2 (error event) sets one edge after an `err_pulse` cycle. A write with bit 2 = 1 clears it.
- R10: Writing 0 to bits 4:2 leaves them unchanged. If a hardware set and a write-one clear of the same flag fall on the same edge, the flag ends at 1.
- R11: `irq` is registered. One edge after any of bits 4, 3 or 2 is 1 with its enable (`ie_sleep`, `ie_wake`, `ie_err`) at 1, `irq` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Asynchronous CAN receive line, 1 = recessive |
| sample_tick | input | 1 | One-cycle strobe at the bit sample point |
| mode_rx | input | 1 | Controller is currently receiver |
| mode_tx | input | 1 | Controller is currently transmitter |
| sleep_ack | input | 1 | Sleep acknowledge level from mode logic |
| init_ack | input | 1 | Init acknowledge level from mode logic |
| err_pulse | input | 1 | One-cycle error event from error logic |
| ie_sleep | input | 1 | Enable for the sleep event flag and its interrupt |
| ie_wake | input | 1 | Interrupt enable for the wakeup flag |
| ie_err | input | 1 | Interrupt enable for the error flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; ones in bits 4:2 clear those flags |
| rd_data | output | 32 | Status word |
| irq | output | 1 | Registered status-change interrupt |

## Verification
A bad synchronizer depth shows at the ports directly. Bit 11 then flips one edge early or late, and the wakeup flag moves with it, so both bits are sampled on each side of the expected edge. A flag whose set or clear logic is wrong may look correct when first set. It only shows once a second event happens on the same edge, a zero is written, or the sleep acknowledge level drops. The bench therefore drives those collisions on purpose and reads the flag one edge later. A broken interrupt combiner shows on `irq` one edge after the flag and enable agree.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int REG_W     = 32;
  localparam int SYNC_LEN  = 2;

  localparam int POS_RXLIVE = 11;
  localparam int POS_SAMP   = 10;
  localparam int POS_RXM    = 9;
  localparam int POS_TXM    = 8;
  localparam int POS_SLPEV  = 4;
  localparam int POS_WAKEV  = 3;
  localparam int POS_ERREV  = 2;
  localparam int POS_INITAK = 1;
  localparam int POS_SLPAK  = 0;

  typedef enum int {
    EV_ERR  = 0,
    EV_WAKE = 1,
    EV_SLP  = 2
  } ev_idx_e;
  localparam int NUM_EV = 3;

  localparam logic [REG_W-1:0] RESET_WORD =
    (REG_W'(1) << POS_RXLIVE) | (REG_W'(1) << POS_SAMP) | (REG_W'(1) << POS_INITAK);

  function automatic int ev_pos(input int idx);
    case (idx)
      EV_ERR:  return POS_ERREV;
      EV_WAKE: return POS_WAKEV;
      default: return POS_SLPEV;
    endcase
  endfunction
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic sample_tick,
  output logic rx_sync,
  output logic rx_samp,
  output logic sof
);
  logic [STAGES-1:0] chain;
  logic              rx_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_LVL}};
        else     chain <= rx_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_LVL}};
        else     chain <= {chain[STAGES-2:0], rx_in};
      end
    end
  endgenerate

  assign rx_sync = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev <= RESET_LVL;
      rx_samp <= RESET_LVL;
    end else begin
      rx_prev <= rx_sync;
      if (sample_tick) rx_samp <= rx_sync;
    end
  end

  assign sof = rx_prev & ~rx_sync;

  AST_SAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> $stable(rx_samp)) else $error("sample bit moved without tick"); // R4
  AST_SOF_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    sof |-> $past(rx_sync)) else $error("sof without prior recessive"); // R8
endmodule

// File: rtl/can_evt_flags.sv
module can_evt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wclr,
  input  logic [N-1:0] aclr,
  output logic [N-1:0] flags
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                  flags[i] <= 1'b0;
        else if (set[i])          flags[i] <= 1'b1;
        else if (wclr[i] | aclr[i]) flags[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set[i] |=> flags[i]) else $error("set lost"); // R10
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[i] && !wclr[i] && !aclr[i]) |=> flags[i]) else $error("flag dropped"); // R10
    end
  endgenerate
endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_pkg::*;
#(
  parameter int W      = REG_W,
  parameter int SYNC_N = SYNC_LEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_pin,
  input  logic         sample_tick,
  input  logic         mode_rx,
  input  logic         mode_tx,
  input  logic         sleep_ack,
  input  logic         init_ack,
  input  logic         err_pulse,
  input  logic         ie_sleep,
  input  logic         ie_wake,
  input  logic         ie_err,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  logic rx_live, rx_samp, sof;
  logic rxm_q, txm_q, slk_q, slk_prev, ink_q;
  logic [NUM_EV-1:0] ev_set, ev_wclr, ev_aclr, ev_q, ev_en;

  can_rx_sync #(.STAGES(SYNC_N), .RESET_LVL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .rx_in(rx_pin), .sample_tick(sample_tick),
    .rx_sync(rx_live), .rx_samp(rx_samp), .sof(sof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rxm_q    <= 1'b0;
      txm_q    <= 1'b0;
      slk_q    <= 1'b0;
      slk_prev <= 1'b0;
      ink_q    <= 1'b1;
    end else begin
      rxm_q    <= mode_rx;
      txm_q    <= mode_tx;
      slk_q    <= sleep_ack;
      slk_prev <= slk_q;
      ink_q    <= init_ack;
    end
  end

  always_comb begin
    ev_set[EV_ERR]  = err_pulse;
    ev_set[EV_WAKE] = sof & slk_q;
    ev_set[EV_SLP]  = slk_q & ~slk_prev & ie_sleep;
    ev_aclr         = '0;
    ev_aclr[EV_SLP] = ~slk_q;
    ev_en[EV_ERR]   = ie_err;
    ev_en[EV_WAKE]  = ie_wake;
    ev_en[EV_SLP]   = ie_sleep;
  end

  genvar k;
  generate
    for (k = 0; k < NUM_EV; k++) begin : g_wclr
      assign ev_wclr[k] = wr_en & wr_data[ev_pos(k)];
    end
  endgenerate

  can_evt_flags #(.N(NUM_EV)) u_flags (
    .clk(clk), .rst(rst), .set(ev_set), .wclr(ev_wclr), .aclr(ev_aclr), .flags(ev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ev_q & ev_en);
  end

  always_comb begin
    rd_data              = '0;
    rd_data[POS_RXLIVE]  = rx_live;
    rd_data[POS_SAMP]    = rx_samp;
    rd_data[POS_RXM]     = rxm_q;
    rd_data[POS_TXM]     = txm_q;
    rd_data[POS_SLPEV]   = ev_q[EV_SLP];
    rd_data[POS_WAKEV]   = ev_q[EV_WAKE];
    rd_data[POS_ERREV]   = ev_q[EV_ERR];
    rd_data[POS_INITAK]  = ink_q;
    rd_data[POS_SLPAK]   = slk_q;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data[W-1:12] == '0) && (rd_data[7:5] == '0)) else $error("reserved set"); // R2
  AST_SLP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[POS_SLPEV]) |-> $past(ie_sleep)) else $error("sleep ev w/o enable"); // R6
  AST_SLP_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
    !rd_data[POS_SLPAK] |=> !rd_data[POS_SLPEV]) else $error("sleep ev not cleared"); // R7
  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[POS_WAKEV]) |-> $past(rd_data[POS_SLPAK])) else $error("wake outside sleep"); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!ie_sleep && !ie_wake && !ie_err) |-> !irq) else $error("irq without enable"); // R11
endmodule

// File: tb/can_stat_reg_bench.sv
module can_stat_reg_bench;
  logic clk = 1'b0;
  logic rst, rx_pin, sample_tick, mode_rx, mode_tx, sleep_ack, init_ack, err_pulse;
  logic ie_sleep, ie_wake, ie_err, wr_en;
  logic [31:0] wr_data, rd_data;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  can_stat_reg u_can_stat_reg (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .sample_tick(sample_tick),
    .mode_rx(mode_rx), .mode_tx(mode_tx), .sleep_ack(sleep_ack), .init_ack(init_ack),
    .err_pulse(err_pulse), .ie_sleep(ie_sleep), .ie_wake(ie_wake), .ie_err(ie_err),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1; rx_pin = 1'b1; sample_tick = 0; mode_rx = 0; mode_tx = 0;
    sleep_ack = 0; init_ack = 1; err_pulse = 0; ie_sleep = 0; ie_wake = 0; ie_err = 0;
    wr_en = 0; wr_data = '0;
    tick(3);
    chk("R1 in reset", rd_data, 32'h0000_0C02);
    rst = 1'b0; tick(2);
    chk("R1 after reset", rd_data, 32'h0000_0C02);
    chk("R11 irq idle", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rsvd;
    wr(32'hFFFF_F0E3);
    tick(1);
    chk("R2 reserved write", rd_data, 32'h0000_0C02);
  endtask

  task automatic t_rx_live;
    rx_pin = 1'b0; sleep_ack = 0;
    tick(1); chk("R3 one edge", {31'b0, rd_data[11]}, 32'h1);
    tick(1); chk("R3 two edges", {31'b0, rd_data[11]}, 32'h0);
    chk("R4 no tick holds", {31'b0, rd_data[10]}, 32'h1);
    sample_tick = 1'b1; tick(1); sample_tick = 1'b0;
    chk("R4 captured", {31'b0, rd_data[10]}, 32'h0);
    chk("R8 no wake awake", {31'b0, rd_data[3]}, 32'h0);
    rx_pin = 1'b1; tick(3);
    chk("R4 held on rise", {31'b0, rd_data[10]}, 32'h0);
    sample_tick = 1'b1; tick(1); sample_tick = 1'b0;
    chk("R4 recaptured", {31'b0, rd_data[10]}, 32'h1);
  endtask

  task automatic t_modes;
    mode_rx = 1; mode_tx = 0; init_ack = 0;
    tick(1);
    chk("R5 rx mode", rd_data & 32'h0000_0303, 32'h0000_0200);
    mode_rx = 0; mode_tx = 1; init_ack = 1;
    tick(1);
    chk("R5 tx mode", rd_data & 32'h0000_0303, 32'h0000_0102);
    mode_tx = 0; tick(1);
  endtask

  task automatic t_sleep;
    ie_sleep = 0; sleep_ack = 1; tick(3);
    chk("R6 no enable", {31'b0, rd_data[4]}, 32'h0);
    chk("R5 sleep ack bit", {31'b0, rd_data[0]}, 32'h1);
    sleep_ack = 0; tick(2);
    ie_sleep = 1; sleep_ack = 1;
    tick(1); chk("R6 one edge", {31'b0, rd_data[4]}, 32'h0);
    tick(1); chk("R6 set", {31'b0, rd_data[4]}, 32'h1);
    tick(1); chk("R11 sleep irq", {31'b0, irq}, 32'h1);
    wr(32'h0); chk("R10 write zero", {31'b0, rd_data[4]}, 32'h1);
    wr(32'h10); chk("R7 w1c", {31'b0, rd_data[4]}, 32'h0);
    sleep_ack = 0; tick(2); sleep_ack = 1; tick(3);
    chk("R6 reset again", {31'b0, rd_data[4]}, 32'h1);
    sleep_ack = 0;
    tick(1); chk("R7 auto one edge", {31'b0, rd_data[4]}, 32'h1);
    tick(1); chk("R7 auto clear", {31'b0, rd_data[4]}, 32'h0);
    ie_sleep = 0; tick(2);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wake;
    sleep_ack = 1; tick(2);
    rx_pin = 0;
    tick(2); chk("R8 early", {31'b0, rd_data[3]}, 32'h0);
    tick(1); chk("R8 set", {31'b0, rd_data[3]}, 32'h1);
    ie_wake = 1; tick(1);
    chk("R11 wake irq", {31'b0, irq}, 32'h1);
    rx_pin = 1; sleep_ack = 0; tick(4);
    chk("R8 sticky", {31'b0, rd_data[3]}, 32'h1);
    wr(32'h08); chk("R8 w1c", {31'b0, rd_data[3]}, 32'h0);
    ie_wake = 0; tick(1);
  endtask

  task automatic t_err;
    err_pulse = 1; tick(1); err_pulse = 0;
    chk("R9 set", {31'b0, rd_data[2]}, 32'h1);
    chk("R11 disabled", {31'b0, irq}, 32'h0);
    err_pulse = 1; wr(32'h04); err_pulse = 0;
    chk("R10 set wins", {31'b0, rd_data[2]}, 32'h1);
    ie_err = 1; tick(1);
    chk("R11 err irq", {31'b0, irq}, 32'h1);
    wr(32'h04); chk("R9 w1c", {31'b0, rd_data[2]}, 32'h0);
    tick(1); chk("R11 cleared", {31'b0, irq}, 32'h0);
    ie_err = 0;
  endtask

  initial begin
    fork
      begin
        t_reset(); t_rsvd(); t_rx_live(); t_modes(); t_sleep(); t_wake(); t_err();
      end
      begin
        tick(100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule